// File: doc/BRIEF.md
# Serial Bus Command Dispatcher

This block sits between a host and the protocol engine of a serial bus controller. The host writes a 3-bit command code. The dispatcher holds the code, raises a busy flag and offers the command to the engine. When the engine takes the command with a one-cycle accept strobe, the dispatcher applies the command's effect to its flags. Whether a command is honoured depends on those flags and on the role the engine reports at that moment.

The dispatcher keeps four pieces of state:
- a master-request flag;
- a slave-request flag;
- a lock flag;
- an idle/wait state.

Stop commands clear the matching request flag and can drive the controller into the wait state. When they do, they send the engine a one-cycle halt pulse.

The host reads two views through one read port. Select 0 is the command register, which always reads zero. Select 1 is a status byte.

Top module: `cmd_dispatcher`

## Requirements
- R1: Reset is synchronous and active-high. While it is applied, and at the first clock after it, all of these are 0: busy, master request, slave request, lock and both halt pulses. The state is idle (`wait_state` = 0).
- R2: A host write while busy is 0 sets busy on the next clock and stores the code, which is shown on `eng_cmd_code`. An `eng_accept` pulse while busy is 1 clears busy on the next clock. The command's effect is applied on that same clock.
- R3: A host write made while busy is 1 is discarded. The stored code stays as it was, and only the earlier command's effect is applied at accept.
- R4: Accepted codes 000, 100 and 111 leave the master request, slave request, lock and wait state unchanged, and produce no halt pulse.
- R5: Accepted code 010 sets the master-request flag. Accepted code 101 sets the slave-request flag.
- R6: `eng_lock_evt` sets the lock flag on the next clock. Accepted code 001 clears it, unless `eng_slave_active` is 1 at the accept clock, in which case the code is ignored. If a lock event and an honoured 001 fall on the same clock, the lock ends up set.
- R7: Accepted code 011 has an effect only when the master request is 1. It then clears the master request, enters the wait state and pulses `eng_halt_master` high for one cycle. With the master request at 0, code 011 changes nothing.
- R8: Accepted code 110 has an effect only when the slave request is 1, and it then clears the slave request. If `eng_slave_tx` is 1 at that clock, it also enters the wait state and pulses `eng_halt_slave` for one cycle. Otherwise the state is left alone. With the slave request at 0, code 110 changes nothing.
- R9: `eng_master_done` clears the master request and `eng_slave_done` clears the slave request. If a done input and a set command for the same flag fall on the same clock, the flag ends up set.
- R10: `host_rd_data` is 0 when `host_rd_sel` is 0. When `host_rd_sel` is 1 it is the status byte, laid out as follows:
  - bit 0: busy
  - bit 1: master request
  - bit 2: slave request
  - bit 3: lock
  - bit 4: wait
  - bits 7:5: zero
- R11: `eng_resume` returns the state from wait to idle. If an honoured stop command falls on the same clock as `eng_resume`, the state ends up in wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_en | input | 1 | Host write strobe for the command register |
| host_wr_cmd | input | 3 | Command code written by the host |
| host_rd_sel | input | 1 | Read select: 0 command register, 1 status |
| host_rd_data | output | 8 | Read data for the selected view |
| eng_accept | input | 1 | One-cycle strobe: engine has taken the pending command |
| eng_lock_evt | input | 1 | One-cycle strobe that sets the lock flag |
| eng_slave_active | input | 1 | A slave exchange is in progress |
| eng_slave_tx | input | 1 | A slave transmission is under way |
| eng_master_done | input | 1 | Master exchange finished normally |
| eng_slave_done | input | 1 | Slave exchange finished normally |
| eng_resume | input | 1 | Leave the wait state |
| eng_cmd_valid | output | 1 | Command pending (busy flag) |
| eng_cmd_code | output | 3 | Stored command code |
| eng_master_req | output | 1 | Master-request flag |
| eng_slave_req | output | 1 | Slave-request flag |
| eng_locked | output | 1 | Lock flag |
| eng_halt_master | output | 1 | One-cycle pulse: master exchange stopped |
| eng_halt_slave | output | 1 | One-cycle pulse: slave transmission stopped |
| wait_state | output | 1 | 1 in the wait state, 0 when idle |

## Verification
The hardest situations to reach are those where a command's outcome depends on inputs that are sampled only on the accept clock. Examples are an unlock arriving while a slave exchange is active, a slave stop with and without a transmission under way, and a stop command landing on the same clock as a resume, a done or a lock event. Directed sequences first build up the needed flags by writing and accepting set commands. They then raise the role inputs and the competing strobes on exactly the accept cycle. A long random stretch follows, in which writes, accepts and engine events collide freely. Throughout, a behavioural model in the bench is compared with every output on every clock.

// File: rtl/cmd_dispatcher_pkg.sv
package cmd_dispatcher_pkg;

    localparam int CMD_W  = 3;
    localparam int REG_W  = 8;

    localparam int STAT_BUSY = 0;
    localparam int STAT_MREQ = 1;
    localparam int STAT_SREQ = 2;
    localparam int STAT_LOCK = 3;
    localparam int STAT_WAIT = 4;

    typedef enum logic [CMD_W-1:0] {
        CMD_NOP    = 3'b000,
        CMD_UNLOCK = 3'b001,
        CMD_MREQ   = 3'b010,
        CMD_MSTOP  = 3'b011,
        CMD_RSV_A  = 3'b100,
        CMD_SREQ   = 3'b101,
        CMD_SSTOP  = 3'b110,
        CMD_RSV_B  = 3'b111
    } cmd_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } ctl_state_e;

    typedef struct packed {
        logic unlock;
        logic set_m;
        logic stop_m;
        logic set_s;
        logic stop_s;
    } cmd_act_t;

    typedef struct packed {
        logic       mreq;
        logic       sreq;
        logic       lock;
        ctl_state_e st;
    } ctl_flags_t;

    function automatic cmd_act_t decode_cmd(input cmd_e c);
        cmd_act_t a;
        a = '0;
        case (c)
            CMD_UNLOCK: a.unlock = 1'b1;
            CMD_MREQ:   a.set_m  = 1'b1;
            CMD_MSTOP:  a.stop_m = 1'b1;
            CMD_SREQ:   a.set_s  = 1'b1;
            CMD_SSTOP:  a.stop_s = 1'b1;
            default:    a = '0;
        endcase
        return a;
    endfunction

    function automatic logic [REG_W-1:0] pack_status(input logic busy,
                                                     input ctl_flags_t f);
        logic [REG_W-1:0] s;
        s            = '0;
        s[STAT_BUSY] = busy;
        s[STAT_MREQ] = f.mreq;
        s[STAT_SREQ] = f.sreq;
        s[STAT_LOCK] = f.lock;
        s[STAT_WAIT] = (f.st == ST_WAIT);
        return s;
    endfunction

endpackage

// File: rtl/cmd_dispatcher_slot.sv
module cmd_dispatcher_slot
    import cmd_dispatcher_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CMD_W-1:0] wr_cmd,
    input  logic             accept,
    output logic             busy,
    output cmd_e             code,
    output logic             take
);

    logic busy_q;
    cmd_e code_q;

    assign take = busy_q & accept;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            code_q <= CMD_NOP;
        end else if (take) begin
            busy_q <= 1'b0;
        end else if (!busy_q && wr_en) begin
            busy_q <= 1'b1;
            code_q <= cmd_e'(wr_cmd);
        end
    end

    assign busy = busy_q;
    assign code = code_q;

endmodule

// File: rtl/cmd_dispatcher_flags.sv
module cmd_dispatcher_flags
    import cmd_dispatcher_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       take,
    input  cmd_e       code,
    input  logic       slave_active,
    input  logic       slave_tx,
    input  logic       lock_evt,
    input  logic       master_done,
    input  logic       slave_done,
    input  logic       resume,
    output ctl_flags_t flags,
    output logic       halt_m,
    output logic       halt_s
);

    ctl_flags_t cur_q, nxt;
    cmd_act_t   act;
    logic       halt_m_d, halt_s_d;
    logic       halt_m_q, halt_s_q;

    always_comb begin
        act      = decode_cmd(code);
        nxt      = cur_q;
        halt_m_d = 1'b0;
        halt_s_d = 1'b0;

        if (master_done) nxt.mreq = 1'b0;
        if (slave_done)  nxt.sreq = 1'b0;
        if (resume)      nxt.st   = ST_IDLE;

        if (take) begin
            if (act.unlock && !slave_active) nxt.lock = 1'b0;
            if (act.set_m) nxt.mreq = 1'b1;
            if (act.set_s) nxt.sreq = 1'b1;
            if (act.stop_m && cur_q.mreq) begin
                nxt.mreq = 1'b0;
                nxt.st   = ST_WAIT;
                halt_m_d = 1'b1;
            end
            if (act.stop_s && cur_q.sreq) begin
                nxt.sreq = 1'b0;
                if (slave_tx) begin
                    nxt.st   = ST_WAIT;
                    halt_s_d = 1'b1;
                end
            end
        end

        if (lock_evt) nxt.lock = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q    <= '{mreq: 1'b0, sreq: 1'b0, lock: 1'b0, st: ST_IDLE};
            halt_m_q <= 1'b0;
            halt_s_q <= 1'b0;
        end else begin
            cur_q    <= nxt;
            halt_m_q <= halt_m_d;
            halt_s_q <= halt_s_d;
        end
    end

    assign flags  = cur_q;
    assign halt_m = halt_m_q;
    assign halt_s = halt_s_q;

endmodule

// File: rtl/cmd_dispatcher_rdmux.sv
module cmd_dispatcher_rdmux
    import cmd_dispatcher_pkg::*;
(
    input  logic             sel,
    input  logic             busy,
    input  ctl_flags_t       flags,
    output logic [REG_W-1:0] data
);

    always_comb begin
        if (sel) data = pack_status(busy, flags);
        else     data = '0;
    end

endmodule

// File: rtl/cmd_dispatcher.sv
module cmd_dispatcher
    import cmd_dispatcher_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             host_wr_en,
    input  logic [CMD_W-1:0] host_wr_cmd,
    input  logic             host_rd_sel,
    output logic [REG_W-1:0] host_rd_data,
    input  logic             eng_accept,
    input  logic             eng_lock_evt,
    input  logic             eng_slave_active,
    input  logic             eng_slave_tx,
    input  logic             eng_master_done,
    input  logic             eng_slave_done,
    input  logic             eng_resume,
    output logic             eng_cmd_valid,
    output logic [CMD_W-1:0] eng_cmd_code,
    output logic             eng_master_req,
    output logic             eng_slave_req,
    output logic             eng_locked,
    output logic             eng_halt_master,
    output logic             eng_halt_slave,
    output logic             wait_state
);

    logic       busy;
    logic       take;
    cmd_e       code;
    ctl_flags_t flags;

    cmd_dispatcher_slot u_slot (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (host_wr_en),
        .wr_cmd (host_wr_cmd),
        .accept (eng_accept),
        .busy   (busy),
        .code   (code),
        .take   (take)
    );

    cmd_dispatcher_flags u_flags (
        .clk          (clk),
        .rst          (rst),
        .take         (take),
        .code         (code),
        .slave_active (eng_slave_active),
        .slave_tx     (eng_slave_tx),
        .lock_evt     (eng_lock_evt),
        .master_done  (eng_master_done),
        .slave_done   (eng_slave_done),
        .resume       (eng_resume),
        .flags        (flags),
        .halt_m       (eng_halt_master),
        .halt_s       (eng_halt_slave)
    );

    cmd_dispatcher_rdmux u_rd (
        .sel   (host_rd_sel),
        .busy  (busy),
        .flags (flags),
        .data  (host_rd_data)
    );

    assign eng_cmd_valid  = busy;
    assign eng_cmd_code   = code;
    assign eng_master_req = flags.mreq;
    assign eng_slave_req  = flags.sreq;
    assign eng_locked     = flags.lock;
    assign wait_state     = (flags.st == ST_WAIT);

endmodule

// File: rtl/cmd_dispatcher_chk.sv
module cmd_dispatcher_chk
    import cmd_dispatcher_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             host_wr_en,
    input logic             host_rd_sel,
    input logic [REG_W-1:0] host_rd_data,
    input logic             eng_accept,
    input logic             eng_lock_evt,
    input logic             eng_cmd_valid,
    input logic [CMD_W-1:0] eng_cmd_code,
    input logic             eng_master_req,
    input logic             eng_halt_master,
    input logic             eng_halt_slave,
    input logic             wait_state
);

    p_busy_set_r2: assert property (@(posedge clk) disable iff (rst)
        (!eng_cmd_valid && host_wr_en) |=> eng_cmd_valid);

    p_busy_clr_r2: assert property (@(posedge clk) disable iff (rst)
        (eng_cmd_valid && eng_accept) |=> !eng_cmd_valid);

    p_discard_r3: assert property (@(posedge clk) disable iff (rst)
        (eng_cmd_valid && host_wr_en && !eng_accept) |=>
            (eng_cmd_valid && $stable(eng_cmd_code)));

    p_lock_set_r6: assert property (@(posedge clk) disable iff (rst)
        eng_lock_evt |=> eng_locked_ok());

    p_halt_wait_r7: assert property (@(posedge clk) disable iff (rst)
        eng_halt_master |-> (wait_state && !eng_master_req));

    p_stop_ignored_r7: assert property (@(posedge clk) disable iff (rst)
        (eng_cmd_valid && eng_accept && eng_cmd_code == CMD_MSTOP && !eng_master_req)
            |=> (!eng_halt_master && !eng_master_req));

    p_halt_excl_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({eng_halt_master, eng_halt_slave}));

    p_halt_s_wait_r8: assert property (@(posedge clk) disable iff (rst)
        eng_halt_slave |-> wait_state);

    p_cmd_reads_zero_r10: assert property (@(posedge clk) disable iff (rst)
        !host_rd_sel |-> (host_rd_data == '0));

    p_status_busy_r10: assert property (@(posedge clk) disable iff (rst)
        host_rd_sel |-> (host_rd_data[STAT_BUSY] == eng_cmd_valid));

    function automatic logic eng_locked_ok();
        return host_rd_sel ? host_rd_data[STAT_LOCK] : 1'b1;
    endfunction

endmodule

bind cmd_dispatcher cmd_dispatcher_chk u_chk (
    .clk             (clk),
    .rst             (rst),
    .host_wr_en      (host_wr_en),
    .host_rd_sel     (host_rd_sel),
    .host_rd_data    (host_rd_data),
    .eng_accept      (eng_accept),
    .eng_lock_evt    (eng_lock_evt),
    .eng_cmd_valid   (eng_cmd_valid),
    .eng_cmd_code    (eng_cmd_code),
    .eng_master_req  (eng_master_req),
    .eng_halt_master (eng_halt_master),
    .eng_halt_slave  (eng_halt_slave),
    .wait_state      (wait_state)
);

// File: tb/cmd_dispatcher_test.sv
`timescale 1ns/1ps
module cmd_dispatcher_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_wr_en = 0;
    logic [2:0] host_wr_cmd = 0;
    logic       host_rd_sel = 0;
    logic [7:0] host_rd_data;
    logic       eng_accept = 0, eng_lock_evt = 0, eng_slave_active = 0, eng_slave_tx = 0;
    logic       eng_master_done = 0, eng_slave_done = 0, eng_resume = 0;
    logic       eng_cmd_valid, eng_master_req, eng_slave_req, eng_locked;
    logic       eng_halt_master, eng_halt_slave, wait_state;
    logic [2:0] eng_cmd_code;

    int n_chk = 0;
    int n_fail = 0;
    bit done_flag = 0;

    always #2.5 clk = ~clk;

    cmd_dispatcher uut (
        .clk(clk), .rst(rst), .host_wr_en(host_wr_en), .host_wr_cmd(host_wr_cmd),
        .host_rd_sel(host_rd_sel), .host_rd_data(host_rd_data),
        .eng_accept(eng_accept), .eng_lock_evt(eng_lock_evt),
        .eng_slave_active(eng_slave_active), .eng_slave_tx(eng_slave_tx),
        .eng_master_done(eng_master_done), .eng_slave_done(eng_slave_done),
        .eng_resume(eng_resume), .eng_cmd_valid(eng_cmd_valid),
        .eng_cmd_code(eng_cmd_code), .eng_master_req(eng_master_req),
        .eng_slave_req(eng_slave_req), .eng_locked(eng_locked),
        .eng_halt_master(eng_halt_master), .eng_halt_slave(eng_halt_slave),
        .wait_state(wait_state)
    );

    // behavioural reference model
    bit       m_busy, m_m, m_s, m_l, m_w, m_hm, m_hs;
    bit [2:0] m_code;

    always @(posedge clk) begin
        bit nb, nm, ns, nl, nw, hm, hs;
        bit [2:0] nc;
        if (rst) begin
            m_busy = 0; m_code = 0; m_m = 0; m_s = 0; m_l = 0; m_w = 0; m_hm = 0; m_hs = 0;
        end else begin
            nb = m_busy; nc = m_code; nm = m_m; ns = m_s; nl = m_l; nw = m_w; hm = 0; hs = 0;
            if (eng_master_done) nm = 0;
            if (eng_slave_done)  ns = 0;
            if (eng_resume)      nw = 0;
            if (m_busy && eng_accept) begin
                nb = 0;
                if (m_code == 3'd1 && !eng_slave_active) nl = 0;
                if (m_code == 3'd2) nm = 1;
                if (m_code == 3'd5) ns = 1;
                if (m_code == 3'd3 && m_m) begin nm = 0; nw = 1; hm = 1; end
                if (m_code == 3'd6 && m_s) begin
                    ns = 0;
                    if (eng_slave_tx) begin nw = 1; hs = 1; end
                end
            end else if (!m_busy && host_wr_en) begin
                nb = 1; nc = host_wr_cmd;
            end
            if (eng_lock_evt) nl = 1;
            m_busy = nb; m_code = nc; m_m = nm; m_s = ns; m_l = nl; m_w = nw; m_hm = hm; m_hs = hs;
        end
    end

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !done_flag) begin
            chk("R2 busy", {7'd0, eng_cmd_valid}, {7'd0, m_busy});
            chk("R3 code", {5'd0, eng_cmd_code}, {5'd0, m_code});
            chk("R5 mreq", {7'd0, eng_master_req}, {7'd0, m_m});
            chk("R9 sreq", {7'd0, eng_slave_req}, {7'd0, m_s});
            chk("R6 lock", {7'd0, eng_locked}, {7'd0, m_l});
            chk("R11 wait", {7'd0, wait_state}, {7'd0, m_w});
            chk("R7 halt_m", {7'd0, eng_halt_master}, {7'd0, m_hm});
            chk("R8 halt_s", {7'd0, eng_halt_slave}, {7'd0, m_hs});
            chk("R10 rd", host_rd_data,
                host_rd_sel ? {3'd0, m_w, m_l, m_s, m_m, m_busy} : 8'h00);
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic clear_pulses();
        host_wr_en = 0; eng_accept = 0; eng_lock_evt = 0;
        eng_master_done = 0; eng_slave_done = 0; eng_resume = 0;
    endtask

    task automatic wr(logic [2:0] c);
        host_wr_en = 1; host_wr_cmd = c; tick(); clear_pulses();
    endtask

    task automatic acc();
        eng_accept = 1; tick(); clear_pulses();
    endtask

    task automatic run_cmd(logic [2:0] c);
        wr(c); acc();
    endtask

    function automatic logic [7:0] status();
        return host_rd_data;
    endfunction

    initial begin
        #500000;
        if (!done_flag) begin
            done_flag = 1;
            n_chk++; n_fail++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        // R1: reset state
        host_rd_sel = 1;
        chk("R1 status during reset", status(), 8'h00);
        rst = 0;
        tick();
        chk("R1 status after reset", status(), 8'h00);

        // R2: busy set and cleared
        wr(3'd2);
        chk("R2 busy after write", status(), 8'h01);
        acc();
        chk("R5 mreq after 010", status(), 8'h02);

        // R7: master stop with request, plus halt pulse
        wr(3'd3); acc();
        chk("R7 stop honoured", {6'd0, eng_halt_master, wait_state}, 8'h03);
        chk("R7 mreq cleared", {7'd0, eng_master_req}, 8'h00);
        tick();
        chk("R7 halt one cycle", {7'd0, eng_halt_master}, 8'h00);
        eng_resume = 1; tick(); clear_pulses();
        chk("R11 resume to idle", {7'd0, wait_state}, 8'h00);

        // R7: master stop without request ignored
        run_cmd(3'd3);
        chk("R7 stop ignored", status(), 8'h00);

        // R6: lock, unlock in slave exchange ignored, then honoured
        eng_lock_evt = 1; tick(); clear_pulses();
        chk("R6 lock set", status(), 8'h08);
        wr(3'd1); eng_slave_active = 1; acc(); eng_slave_active = 0;
        chk("R6 unlock ignored in slave", status(), 8'h08);
        run_cmd(3'd1);
        chk("R6 unlock honoured", status(), 8'h00);
        eng_lock_evt = 1; tick(); clear_pulses();
        wr(3'd1); eng_accept = 1; eng_lock_evt = 1; tick(); clear_pulses();
        chk("R6 lock event wins", {7'd0, eng_locked}, 8'h01);
        run_cmd(3'd1);

        // R8: slave stop during transmission
        run_cmd(3'd5);
        chk("R5 sreq set", status(), 8'h04);
        wr(3'd6); eng_slave_tx = 1; acc(); eng_slave_tx = 0;
        chk("R8 stop with tx", {5'd0, eng_halt_slave, eng_slave_req, wait_state}, 8'h05);
        eng_resume = 1; tick(); clear_pulses();
        run_cmd(3'd5);
        run_cmd(3'd6);
        chk("R8 stop before tx", status(), 8'h00);
        run_cmd(3'd6);
        chk("R8 stop no request ignored", status(), 8'h00);

        // R4: no-effect codes with flags present
        run_cmd(3'd2); run_cmd(3'd5);
        eng_lock_evt = 1; tick(); clear_pulses();
        run_cmd(3'd0); run_cmd(3'd4); run_cmd(3'd7);
        chk("R4 reserved codes no effect", status(), 8'h0E);

        // R9: done clears, done vs set same cycle
        eng_master_done = 1; eng_slave_done = 1; tick(); clear_pulses();
        chk("R9 done clears", status(), 8'h08);
        wr(3'd2); eng_accept = 1; eng_master_done = 1; tick(); clear_pulses();
        chk("R9 set beats done", {7'd0, eng_master_req}, 8'h01);

        // R11: stop and resume same cycle -> wait
        wr(3'd3); eng_accept = 1; eng_resume = 1; tick(); clear_pulses();
        chk("R11 stop beats resume", {7'd0, wait_state}, 8'h01);
        eng_resume = 1; tick(); clear_pulses();

        // R3: write while busy discarded
        wr(3'd2); wr(3'd5);
        chk("R3 code kept", {5'd0, eng_cmd_code}, 8'h02);
        acc();
        chk("R3 only first applied", {6'd0, eng_slave_req, eng_master_req}, 8'h01);

        // R10: command register view reads zero
        host_rd_sel = 0; tick();
        chk("R10 cmd view zero", host_rd_data, 8'h00);

        // random collisions, compared against the model every clock
        for (int i = 0; i < 3000; i++) begin
            host_wr_en       = ($urandom % 4) == 0;
            host_wr_cmd      = 3'($urandom);
            host_rd_sel      = 1'($urandom);
            eng_accept       = ($urandom % 3) == 0;
            eng_lock_evt     = ($urandom % 8) == 0;
            eng_slave_active = 1'($urandom);
            eng_slave_tx     = 1'($urandom);
            eng_master_done  = ($urandom % 8) == 0;
            eng_slave_done   = ($urandom % 8) == 0;
            eng_resume       = ($urandom % 8) == 0;
            tick();
        end
        clear_pulses();
        rst = 1; tick(); tick();
        chk("R1 reset after activity", {eng_halt_master, eng_halt_slave, eng_cmd_valid,
            eng_master_req, eng_slave_req, eng_locked, wait_state, 1'b0}, 8'h00);

        done_flag = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule